// File: doc/BRIEF.md
# Indexed-Colour Display Controller Register File

This block is the register and table store of an 8-bit indexed-colour display controller. A host reaches it through a 32-bit, word-wide bus. Writes take effect on the next clock edge. A read returns its data one cycle after the request. The block holds four kinds of state:

- a 256-entry colour lookup table;
- a three-entry cursor colour table;
- a 512-word cursor bitmap store;
- three single registers: control, top-of-screen offset and cursor position.

The decoder turns a byte offset into a table index at an eight-byte stride. Colour entries are packed into and out of 24-bit RGB. The control word is turned into a pixel-depth value, a forced-blank flag and a cursor-disable flag, which drive the scan-out logic that sits next to this block. The block also owns the frame interrupt. A frame-complete pulse raises it, and any bus write drops it. Video timing, the frame store and pixel output are outside this block.

Top module: `dispCtlRegs`

## Requirements
- R1: The byte offsets 0x800 to 0xFFF map to the colour lookup table. The entry index is (offset - 0x800) >> 3, giving 256 entries. Offset bits 2:0 are ignored, so 0x805 reaches entry 0.
- R2: A colour entry is written from, and read back in, the layout blue = bits 7:0, green = bits 15:8, red = bits 23:16. Bits 31:24 of the write data are dropped, and they read back as zero.
- R3: The offsets 0x508 to 0x51F map to the three cursor colour entries, index (offset - 0x508) >> 3. These entries use the R2 layout and are readable and writable.
- R4: The offsets 0x1000 to 0x1FFF map to 512 cursor bitmap words, index (offset - 0x1000) >> 3. Each word holds bits 15:0 of the write data, and bits 31:16 read back as zero.
- R5: The control word sits at 0x300 and is read back in full. The output blankForce equals control bit 10, and cursorOff equals control bit 23.
- R6: Control bits 22:20 select the depth. Codes 0 to 5 give pixDepth 1, 2, 4, 8, 15 and 16 with depthValid high. Codes 6 and 7 give pixDepth 0 with depthValid low. The depth outputs change only after a control write.
- R7: The register at 0x638 keeps 24 bits. Bits 23:12 drive cursorX and bits 11:0 drive cursorY, and bits 31:24 read back as zero. The register at 0x400 keeps a full 32-bit top-of-screen offset, which drives topOffset. Both registers are readable. Their outputs change only after a write to them.
- R8: Writes to the timing offsets 0x000, 0x108 to 0x170 and 0x200, and writes to any other unmapped offset, change no state. Single registers match on offset bits 12:3.
- R9: A read request (rdEn) gives rdValid high in the next cycle, with rdData for the addressed state. A read of an unmapped or write-only offset (the timing offsets included) returns zero and pulses rdErr in the same cycle as rdValid. When no read is in progress, rdData is zero.
- R10: A frameDone pulse makes frameIrq high from the next cycle. frameIrq then stays high until a write of any offset clears it in the following cycle. If frameDone and a write arrive in the same cycle, frameIrq is set. Reads leave frameIrq unchanged.
- R11: Reset (rstN low) clears all tables, the bitmap store, the control, top and cursor registers, and frameIrq. After reset, pixDepth is 1 and depthValid is high (code 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write request for this cycle |
| rdEn | input | 1 | Read request for this cycle |
| addr | input | 13 | Byte offset of the access |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid while rdValid is high |
| rdValid | output | 1 | Read answer, one cycle after rdEn |
| rdErr | output | 1 | Read hit an unmapped or write-only offset |
| frameDone | input | 1 | Frame-complete pulse from the video timing |
| frameIrq | output | 1 | Frame interrupt |
| blankForce | output | 1 | Force the screen blank |
| cursorOff | output | 1 | Disable the cursor overlay |
| pixDepth | output | 5 | Bits per pixel, 0 when the code is invalid |
| depthValid | output | 1 | Depth code is one of the defined values |
| topOffset | output | 32 | Top-of-screen offset into the frame store |
| cursorX | output | 12 | Cursor X coordinate |
| cursorY | output | 12 | Cursor Y coordinate |

## Verification
State written by a write request is visible on the decoded outputs one clock edge later. A read's data, rdValid and rdErr appear one edge after rdEn and last a single cycle. The frame interrupt reacts one edge after frameDone or a write. The bench drives every request on a falling edge and removes it on the next falling edge. It samples all outputs at that second falling edge, which falls exactly in the cycle after the single register stage. Unchanged-state checks after discarded writes are read through the bus and the decoded outputs before any further write.

// File: rtl/dispCtlPkg.sv
package dispCtlPkg;

  localparam int CLUT_N    = 256;
  localparam int CCLR_N    = 3;
  localparam int PAT_N     = 512;
  localparam int STRIDE_LG = 3;
  localparam int IDX_W     = $clog2(PAT_N);

  localparam logic [31:0] CLUT_BASE = 32'h0000_0800;
  localparam logic [31:0] CCLR_BASE = 32'h0000_0508;
  localparam logic [31:0] PAT_BASE  = 32'h0000_1000;
  localparam logic [31:0] CTL_ADDR  = 32'h0000_0300;
  localparam logic [31:0] TOP_ADDR  = 32'h0000_0400;
  localparam logic [31:0] POS_ADDR  = 32'h0000_0638;

  localparam int CTL_BLANK_BIT  = 10;
  localparam int CTL_NOCURS_BIT = 23;
  localparam int DEPTH_LSB      = 20;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CLUT,
    SEL_CCLR,
    SEL_PAT,
    SEL_CTL,
    SEL_TOP,
    SEL_POS
  } regSel_e;

  typedef struct packed {
    logic             clutWe;
    logic             cclrWe;
    logic             patWe;
    logic             ctlWe;
    logic             topWe;
    logic             posWe;
    logic             rdEn;
    regSel_e          sel;
    logic [IDX_W-1:0] idx;
  } strobe_t;

endpackage

// File: rtl/dispCtlDecode.sv
module dispCtlDecode
  import dispCtlPkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              frameDone,
  output strobe_t           stb,
  output logic              rdValid,
  output logic              rdErr,
  output logic              frameIrq
);

  localparam logic [31:0] CLUT_HI = CLUT_BASE + 32'(CLUT_N << STRIDE_LG);
  localparam logic [31:0] CCLR_HI = CCLR_BASE + 32'(CCLR_N << STRIDE_LG);
  localparam logic [31:0] PAT_HI  = PAT_BASE + 32'(PAT_N << STRIDE_LG);

  logic [31:0] offs;
  regSel_e     sel;
  logic [IDX_W-1:0] idx;

  assign offs = 32'(addr);

  // Range decode; a bitmap or table hit yields an index at an 8-byte stride
  always_comb begin
    sel = SEL_NONE;
    idx = '0;
    if (offs >= PAT_BASE && offs < PAT_HI) begin
      sel = SEL_PAT;
      idx = IDX_W'((offs - PAT_BASE) >> STRIDE_LG);
    end else if (offs >= CLUT_BASE && offs < CLUT_HI) begin
      sel = SEL_CLUT;
      idx = IDX_W'((offs - CLUT_BASE) >> STRIDE_LG);
    end else if (offs >= CCLR_BASE && offs < CCLR_HI) begin
      sel = SEL_CCLR;
      idx = IDX_W'((offs - CCLR_BASE) >> STRIDE_LG);
    end else if (offs[31:STRIDE_LG] == CTL_ADDR[31:STRIDE_LG]) begin
      sel = SEL_CTL;
    end else if (offs[31:STRIDE_LG] == TOP_ADDR[31:STRIDE_LG]) begin
      sel = SEL_TOP;
    end else if (offs[31:STRIDE_LG] == POS_ADDR[31:STRIDE_LG]) begin
      sel = SEL_POS;
    end
  end

  always_comb begin
    stb.clutWe = wrEn && (sel == SEL_CLUT);
    stb.cclrWe = wrEn && (sel == SEL_CCLR);
    stb.patWe  = wrEn && (sel == SEL_PAT);
    stb.ctlWe  = wrEn && (sel == SEL_CTL);
    stb.topWe  = wrEn && (sel == SEL_TOP);
    stb.posWe  = wrEn && (sel == SEL_POS);
    stb.rdEn   = rdEn;
    stb.sel    = sel;
    stb.idx    = idx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdErr   <= 1'b0;
    end else begin
      rdValid <= rdEn;
      rdErr   <= rdEn && (sel == SEL_NONE);
    end
  end

  // Frame pulse wins over a clearing write in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameIrq <= 1'b0;
    end else if (frameDone) begin
      frameIrq <= 1'b1;
    end else if (wrEn) begin
      frameIrq <= 1'b0;
    end
  end

  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid); // R9
  AST_ERR_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN)
    rdErr |-> rdValid); // R9
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> frameIrq); // R10
  AST_WRITE_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !frameDone) |=> !frameIrq); // R10
  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameIrq) |-> $past(frameDone)); // R10

endmodule

// File: rtl/dispCtlStore.sv
module dispCtlStore
  import dispCtlPkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int COLOR_W = 24,
  parameter int PAT_W   = 16,
  parameter int COORD_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              blankForce,
  output logic              cursorOff,
  output logic [4:0]        pixDepth,
  output logic              depthValid,
  output logic [DATA_W-1:0] topOffset,
  output logic [COORD_W-1:0] cursorX,
  output logic [COORD_W-1:0] cursorY
);

  localparam int CLUT_IW = $clog2(CLUT_N);
  localparam int CCLR_IW = $clog2(CCLR_N);
  localparam int POS_W   = 2 * COORD_W;

  logic [COLOR_W-1:0] clut [CLUT_N];
  logic [COLOR_W-1:0] cclr [CCLR_N];
  logic [PAT_W-1:0]   pat  [PAT_N];
  logic [DATA_W-1:0]  ctlReg;
  logic [DATA_W-1:0]  topReg;
  logic [POS_W-1:0]   posReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < CLUT_N; i++) clut[i] <= '0;
    end else if (stb.clutWe) begin
      clut[stb.idx[CLUT_IW-1:0]] <= wrData[COLOR_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < CCLR_N; i++) cclr[i] <= '0;
    end else if (stb.cclrWe && (int'(stb.idx) < CCLR_N)) begin
      cclr[stb.idx[CCLR_IW-1:0]] <= wrData[COLOR_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < PAT_N; i++) pat[i] <= '0;
    end else if (stb.patWe) begin
      pat[stb.idx] <= wrData[PAT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlReg <= '0;
      topReg <= '0;
      posReg <= '0;
    end else begin
      if (stb.ctlWe) ctlReg <= wrData;
      if (stb.topWe) topReg <= wrData;
      if (stb.posWe) posReg <= wrData[POS_W-1:0];
    end
  end

  // Registered read port; idle cycles return zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (!stb.rdEn) begin
      rdData <= '0;
    end else begin
      unique case (stb.sel)
        SEL_CLUT: rdData <= DATA_W'(clut[stb.idx[CLUT_IW-1:0]]);
        SEL_CCLR: rdData <= (int'(stb.idx) < CCLR_N) ?
                            DATA_W'(cclr[stb.idx[CCLR_IW-1:0]]) : '0;
        SEL_PAT:  rdData <= DATA_W'(pat[stb.idx]);
        SEL_CTL:  rdData <= ctlReg;
        SEL_TOP:  rdData <= topReg;
        SEL_POS:  rdData <= DATA_W'(posReg);
        default:  rdData <= '0;
      endcase
    end
  end

  function automatic logic [5:0] depthOf(input logic [2:0] code);
    case (code)
      3'd0:    depthOf = {1'b1, 5'd1};
      3'd1:    depthOf = {1'b1, 5'd2};
      3'd2:    depthOf = {1'b1, 5'd4};
      3'd3:    depthOf = {1'b1, 5'd8};
      3'd4:    depthOf = {1'b1, 5'd15};
      3'd5:    depthOf = {1'b1, 5'd16};
      default: depthOf = {1'b0, 5'd0};
    endcase
  endfunction

  always_comb begin
    {depthValid, pixDepth} = depthOf(ctlReg[DEPTH_LSB +: 3]);
    blankForce = ctlReg[CTL_BLANK_BIT];
    cursorOff  = ctlReg[CTL_NOCURS_BIT];
    topOffset  = topReg;
    cursorX    = posReg[POS_W-1:COORD_W];
    cursorY    = posReg[COORD_W-1:0];
  end

  AST_DEPTH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.ctlWe |=> $stable({depthValid, pixDepth})); // R6
  AST_CURSOR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.posWe |=> $stable({cursorX, cursorY})); // R7
  AST_TOP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.topWe |=> $stable(topOffset)); // R7

endmodule

// File: rtl/dispCtlRegs.sv
module dispCtlRegs
  import dispCtlPkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int DATA_W  = 32,
  parameter int COORD_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic               rdValid,
  output logic               rdErr,
  input  logic               frameDone,
  output logic               frameIrq,
  output logic               blankForce,
  output logic               cursorOff,
  output logic [4:0]         pixDepth,
  output logic               depthValid,
  output logic [DATA_W-1:0]  topOffset,
  output logic [COORD_W-1:0] cursorX,
  output logic [COORD_W-1:0] cursorY
);

  strobe_t stb;

  dispCtlDecode #(.ADDR_W(ADDR_W)) uDecode (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .rdEn      (rdEn),
    .addr      (addr),
    .frameDone (frameDone),
    .stb       (stb),
    .rdValid   (rdValid),
    .rdErr     (rdErr),
    .frameIrq  (frameIrq)
  );

  dispCtlStore #(.DATA_W(DATA_W), .COORD_W(COORD_W)) uStore (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .wrData     (wrData),
    .rdData     (rdData),
    .blankForce (blankForce),
    .cursorOff  (cursorOff),
    .pixDepth   (pixDepth),
    .depthValid (depthValid),
    .topOffset  (topOffset),
    .cursorX    (cursorX),
    .cursorY    (cursorY)
  );

  AST_ERR_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rdErr |-> (rdData == '0)); // R9

endmodule

// File: tb/dispCtlRegs_test.sv
module dispCtlRegs_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [12:0] addr = '0;
  logic [31:0] wrData = '0;
  logic        frameDone = 1'b0;
  logic [31:0] rdData;
  logic        rdValid, rdErr, frameIrq, blankForce, cursorOff, depthValid;
  logic [4:0]  pixDepth;
  logic [31:0] topOffset;
  logic [11:0] cursorX, cursorY;

  int checkCnt = 0;
  int failCnt  = 0;

  logic [23:0] mClut [256];
  logic [23:0] mCclr [3];
  logic [15:0] mPat  [512];
  logic [31:0] mCtl, mTop;
  logic [23:0] mPos;

  always #2 clk = ~clk;

  dispCtlRegs uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .rdValid(rdValid), .rdErr(rdErr),
    .frameDone(frameDone), .frameIrq(frameIrq), .blankForce(blankForce),
    .cursorOff(cursorOff), .pixDepth(pixDepth), .depthValid(depthValid),
    .topOffset(topOffset), .cursorX(cursorX), .cursorY(cursorY)
  );

  task automatic clearModel();
    for (int i = 0; i < 256; i++) mClut[i] = '0;
    for (int i = 0; i < 3; i++) mCclr[i] = '0;
    for (int i = 0; i < 512; i++) mPat[i] = '0;
    mCtl = '0; mTop = '0; mPos = '0;
  endtask

  function automatic string tagOf(input int unsigned a);
    if (a >= 32'h1000) return "R4";
    if (a >= 32'h800) return "R1";
    if (a >= 32'h508 && a < 32'h520) return "R3";
    if ((a >> 3) == (32'h300 >> 3)) return "R5";
    if ((a >> 3) == (32'h400 >> 3) || (a >> 3) == (32'h638 >> 3)) return "R7";
    return "R9";
  endfunction

  function automatic logic [32:0] expRead(input int unsigned a);
    if (a >= 32'h1000 && a < 32'h2000) return {17'h0, mPat[(a - 32'h1000) >> 3]};
    if (a >= 32'h800) return {9'h0, mClut[(a - 32'h800) >> 3]};
    if (a >= 32'h508 && a < 32'h520) return {9'h0, mCclr[(a - 32'h508) >> 3]};
    if ((a >> 3) == (32'h300 >> 3)) return {1'b0, mCtl};
    if ((a >> 3) == (32'h400 >> 3)) return {1'b0, mTop};
    if ((a >> 3) == (32'h638 >> 3)) return {9'h0, mPos};
    return {1'b1, 32'h0};
  endfunction

  task automatic applyWrite(input int unsigned a, input logic [31:0] d);
    if (a >= 32'h1000 && a < 32'h2000) mPat[(a - 32'h1000) >> 3] = d[15:0];
    else if (a >= 32'h800) mClut[(a - 32'h800) >> 3] = d[23:0];
    else if (a >= 32'h508 && a < 32'h520) mCclr[(a - 32'h508) >> 3] = d[23:0];
    else if ((a >> 3) == (32'h300 >> 3)) mCtl = d;
    else if ((a >> 3) == (32'h400 >> 3)) mTop = d;
    else if ((a >> 3) == (32'h638 >> 3)) mPos = d[23:0];
  endtask

  function automatic logic [5:0] expDepth(input logic [2:0] c);
    case (c)
      3'd0: return {1'b1, 5'd1};
      3'd1: return {1'b1, 5'd2};
      3'd2: return {1'b1, 5'd4};
      3'd3: return {1'b1, 5'd8};
      3'd4: return {1'b1, 5'd15};
      3'd5: return {1'b1, 5'd16};
      default: return 6'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [32:0] act, input logic [32:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    applyWrite(32'(a), d);
  endtask

  task automatic readCheck(input logic [12:0] a);
    logic [32:0] e;
    string t;
    e = expRead(32'(a));
    t = tagOf(32'(a));
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    check({t, " R9 rdValid"}, 33'(rdValid), 33'd1);
    check({t, " read data/err"}, {rdErr, rdData}, e);
  endtask

  task automatic checkOutputs(input string t);
    logic [5:0] d;
    d = expDepth(mCtl[22:20]);
    check({t, " R5 blankForce"}, 33'(blankForce), 33'(mCtl[10]));
    check({t, " R5 cursorOff"}, 33'(cursorOff), 33'(mCtl[23]));
    check({t, " R6 depth"}, 33'({depthValid, pixDepth}), 33'(d));
    check({t, " R7 topOffset"}, 33'(topOffset), 33'(mTop));
    check({t, " R7 cursor"}, 33'({cursorX, cursorY}), 33'(mPos));
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    clearModel();
  endtask

  function automatic logic [12:0] pickAddr();
    int unsigned r;
    r = $urandom % 8;
    case (r)
      0: return 13'($urandom % 32'h2000);
      1: return 13'(32'h508 + $urandom % 32'h18);
      2: return 13'(32'h300 + $urandom % 8);
      3: return 13'(32'h400 + $urandom % 8);
      4: return 13'(32'h638 + $urandom % 8);
      5: return 13'(32'h108 + 8 * ($urandom % 14));
      6: return 13'(32'h800 + $urandom % 32'h800);
      default: return 13'(32'h1000 + $urandom % 32'h1000);
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    void'($urandom(32'd24681));
    clearModel();
    doReset();

    // R11: reset state
    @(negedge clk);
    check("R11 frameIrq", 33'(frameIrq), 33'd0);
    check("R11 rdValid idle", 33'(rdValid), 33'd0);
    check("R11 rdData idle R9", 33'(rdData), 33'd0);
    checkOutputs("R11 reset");
    readCheck(13'h800); readCheck(13'h1FF8); readCheck(13'h510); readCheck(13'h638);

    // R1/R2: packing, upper byte dropped, low bits ignored
    doWrite(13'h828, 32'hAB12_3456);
    readCheck(13'h828);
    check("R2 packed readback", expRead(32'h828), 33'h0_0012_3456);
    doWrite(13'h805, 32'h00FF_0000);
    readCheck(13'h800);
    readCheck(13'hFFF);
    doWrite(13'hFF8, 32'h0000_00C3);
    readCheck(13'hFFB);
    // R3 and R4 boundaries
    doWrite(13'h508, 32'h0011_2233);
    doWrite(13'h51F, 32'hFF44_5566);
    readCheck(13'h518);
    readCheck(13'h520);
    doWrite(13'h1000, 32'hDEAD_BEEF);
    doWrite(13'h1FFF, 32'h1234_5678);
    readCheck(13'h1000);
    readCheck(13'h1FF8);

    // R5/R6: every depth code
    for (int c = 0; c < 8; c++) begin
      doWrite(13'h300, (32'(c) << 20) | (32'(c & 1) << 10) | (32'((c >> 1) & 1) << 23));
      checkOutputs("R6 sweep");
    end
    readCheck(13'h300);

    // R7: position and top
    doWrite(13'h638, 32'hFFAB_C123);
    doWrite(13'h400, 32'h8765_4321);
    checkOutputs("R7 directed");
    check("R7 cursorX", 33'(cursorX), 33'h0ABC);
    readCheck(13'h638);
    readCheck(13'h400);

    // R8: timing and unmapped writes are discarded
    doWrite(13'h000, 32'hFFFF_FFFF);
    for (int k = 0; k < 14; k++) doWrite(13'(32'h108 + 8 * k), $urandom);
    doWrite(13'h200, 32'hFFFF_FFFF);
    doWrite(13'h7F8, 32'hFFFF_FFFF);
    checkOutputs("R8 after discarded writes");
    readCheck(13'h300); readCheck(13'h400); readCheck(13'h638);
    readCheck(13'h000); readCheck(13'h170); readCheck(13'h200);

    // R10: interrupt
    @(negedge clk); frameDone = 1'b1;
    @(negedge clk); frameDone = 1'b0;
    check("R10 set by frameDone", 33'(frameIrq), 33'd1);
    repeat (3) @(negedge clk);
    check("R10 held", 33'(frameIrq), 33'd1);
    readCheck(13'h300);
    check("R10 read keeps irq", 33'(frameIrq), 33'd1);
    doWrite(13'h7F0, 32'h0);
    check("R10 write clears", 33'(frameIrq), 33'd0);
    @(negedge clk); frameDone = 1'b1; wrEn = 1'b1; addr = 13'h7F0; wrData = '0;
    @(negedge clk); frameDone = 1'b0; wrEn = 1'b0;
    check("R10 frameDone wins", 33'(frameIrq), 33'd1);
    doWrite(13'h300, mCtl);
    check("R10 mapped write clears", 33'(frameIrq), 33'd0);

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      logic [12:0] a;
      a = pickAddr();
      if ($urandom % 2 == 0) begin
        doWrite(a, $urandom);
        checkOutputs("random write");
      end else begin
        readCheck(a);
      end
    end

    // R11: reset after traffic
    doWrite(13'h300, 32'h00D0_0400);
    doWrite(13'h900, 32'h00AB_CDEF);
    @(negedge clk); frameDone = 1'b1;
    @(negedge clk); frameDone = 1'b0;
    doReset();
    @(negedge clk);
    check("R11 irq after reset", 33'(frameIrq), 33'd0);
    checkOutputs("R11 after reset");
    readCheck(13'h900); readCheck(13'h300); readCheck(13'h1008);

    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

endmodule